// File: doc/BRIEF.md
# SMBus Indexed Register Target

This block answers as a target on a two-wire SMBus segment and keeps a bank of eight byte-wide control and identification registers. The rest of the chip sees the whole bank as one flat vector. A host writes a block by giving a starting index, then a byte count, then the data. To read a block, the host gives the index, issues a repeated START and addresses the target for reading. The target then returns a count byte followed by the register contents.

The SCL and SDA pins reach the block as levels that a fast system clock samples. The block resynchronises both lines and detects edges, START and STOP on the sampled values. It returns a single enable that pulls SDA low when asserted. A strap pin sets the bus address. The strap is captured at the first rising edge of the power-good input, and the block keeps that value from then on.

Register map (index: reset value / writable bits): 0: FF / FF, 1: 00 / 3B, 2: FF / FF, 3: 10 / F0, 4: 00 / none (reserved), 5: 11 / none, 6: 08 / none, 7: 08 / 1F (read-back count).

Top module: `smb_regbank`

## Requirements
- R1: The 7-bit target address is 0x68 when the strap was 0 and 0x6A when it was 1. The strap is sampled at the first rising edge of power-good only. Later strap changes and later power-good pulses leave the address unchanged.
- R2: Until power-good has risen once, the target acknowledges nothing and never pulls SDA low.
- R3: An address byte that does not match is not acknowledged. Every following byte up to the next START is also not acknowledged and writes nothing.
- R4: In a write, the target acknowledges the address (R/W bit 0), the index byte and the count byte. It then writes each data byte to consecutive locations starting at the index and acknowledges each one.
- R5: Data bytes beyond the written count are not acknowledged and do not change any register.
- R6: After a write of the index, a repeated START and the address with R/W bit 1, the first byte returned is bits [4:0] of register 7 with bits [7:5] zero. The register contents then follow from the index onward, MSB first.
- R7: Exactly as many data bytes as the count byte states are taken from the registers. Any byte the host acknowledges after that reads 0xFF, because SDA stays released.
- R8: Only the writable bits listed in the map change on a write. Register 4 stays 0x00, register 5 stays 0x11, register 6 stays 0x08, and register 7 bits [7:5] stay 0.
- R9: After reset, the register vector holds the reset values of the map. Register i occupies bits [8i+7:8i].
- R10: The index advances by one per data byte and stops at 7, so further bytes write or read register 7 again. An index of 8 or more writes nothing and reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level (wired-AND of all drivers) |
| pwrgd_i | input | 1 | Power-good; first rising edge captures the strap |
| addr_strap_i | input | 1 | Address select strap |
| sda_oe_o | output | 1 | When high, the SDA pad is pulled low |
| regs_o | output | 64 | Register bank, register i at bits [8i+7:8i] |

## Verification
Two pairs of events can fall in the same cycle. The first is the power-good rising edge and a strap change. The bench raises the strap in the very cycle that power-good rises, drops it a few cycles later, and then pulses power-good again with the strap low. It judges the result by which address is acknowledged afterwards. The second pair is index saturation and count exhaustion in the same byte. Writes that start near register 7 with counts that run past it must leave the last byte in register 7 and NACK the surplus. Reads across the end must repeat register 7 and then return 0xFF. A reference model in the bench replays every write with the writable masks, and random transfers keep comparing the model against both the read-back stream and the register vector.

// File: rtl/smb_regbank_pkg.sv
package smb_regbank_pkg;

   localparam int BYTE_W = 8;
   localparam int IDX_W  = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK1,
      ST_ACK2,
      ST_TX,
      ST_TACK,
      ST_IGN
   } tgt_state_t;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_INDEX,
      PH_COUNT,
      PH_DATA
   } rx_phase_t;

   // Value a register takes at reset.
   function automatic logic [BYTE_W-1:0] reg_init(input int i);
      case (i)
         0, 2:    return 8'hFF;
         3:       return 8'h10;
         5:       return 8'h11;
         6, 7:    return 8'h08;
         default: return 8'h00;
      endcase
   endfunction

   // Bits a bus write may change; zero marks read-only or reserved.
   function automatic logic [BYTE_W-1:0] reg_wmask(input int i);
      case (i)
         0, 2:    return 8'hFF;
         1:       return 8'h3B;
         3:       return 8'hF0;
         7:       return 8'h1F;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
   import smb_regbank_pkg::*;
#(
   parameter int NREG = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic [BYTE_W-1:0]      wr_data,
   input  logic [IDX_W-1:0]       rd_idx,
   output logic [BYTE_W-1:0]      rd_data,
   output logic [NREG*BYTE_W-1:0] regs_flat
);

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam logic [BYTE_W-1:0] INIT = reg_init(g);
      localparam logic [BYTE_W-1:0] MASK = reg_wmask(g);
      logic [BYTE_W-1:0] q;

      if (MASK == '0) begin : g_const
         assign q = INIT;
      end else begin : g_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= INIT;
            else if (wr_en && wr_idx == IDX_W'(g))
               q <= (q & ~MASK) | (wr_data & MASK);
         end
      end

      assign regs_flat[g*BYTE_W +: BYTE_W] = q;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NREG; i++)
         if (rd_idx == IDX_W'(i))
            rd_data = regs_flat[i*BYTE_W +: BYTE_W];
   end

endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
   import smb_regbank_pkg::*;
#(
   parameter int NREG = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic              addr_ok,
   input  logic [6:0]        my_addr,
   input  logic [BYTE_W-1:0] cnt_byte,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [BYTE_W-1:0] wr_data,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              sda_oe,
   output logic              ignoring
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NREG-1);

   tgt_state_t        state;
   rx_phase_t         phase;
   logic [2:0]        bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic [BYTE_W-1:0] txsh;
   logic [IDX_W-1:0]  idx;
   logic [BYTE_W-1:0] remain;
   logic [BYTE_W-1:0] rd_left;
   logic              ack_q;
   logic              to_tx;
   logic              acked;
   logic [BYTE_W-1:0] rx_byte;

   function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] v);
      return (v < LAST_IDX) ? v + 1'b1 : v;
   endfunction

   assign rx_byte  = {shreg[6:0], sda_s};
   assign rd_idx   = idx;
   assign ignoring = (state == ST_IGN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         phase   <= PH_ADDR;
         bitcnt  <= '0;
         shreg   <= '0;
         txsh    <= '0;
         idx     <= '0;
         remain  <= '0;
         rd_left <= '0;
         ack_q   <= 1'b0;
         to_tx   <= 1'b0;
         acked   <= 1'b0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_idx  <= '0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            state  <= ST_RX;
            phase  <= PH_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_RX: if (scl_rise) begin
                  shreg <= rx_byte;
                  if (bitcnt == 3'd7) begin
                     bitcnt <= '0;
                     state  <= ST_ACK1;
                     to_tx  <= 1'b0;
                     case (phase)
                        PH_ADDR: begin
                           ack_q <= addr_ok && (rx_byte[7:1] == my_addr);
                           if (addr_ok && rx_byte[7:1] == my_addr) begin
                              if (rx_byte[0]) begin
                                 to_tx   <= 1'b1;
                                 txsh    <= cnt_byte;
                                 rd_left <= cnt_byte;
                              end else begin
                                 phase <= PH_INDEX;
                              end
                           end
                        end
                        PH_INDEX: begin
                           ack_q <= 1'b1;
                           idx   <= rx_byte;
                           phase <= PH_COUNT;
                        end
                        PH_COUNT: begin
                           ack_q  <= 1'b1;
                           remain <= rx_byte;
                           phase  <= PH_DATA;
                        end
                        default: begin
                           ack_q <= (remain != '0);
                           if (remain != '0) begin
                              wr_en   <= 1'b1;
                              wr_idx  <= idx;
                              wr_data <= rx_byte;
                              idx     <= step_idx(idx);
                              remain  <= remain - 1'b1;
                           end
                        end
                     endcase
                  end else begin
                     bitcnt <= bitcnt + 3'd1;
                  end
               end
               ST_ACK1: if (scl_fall) begin
                  sda_oe <= ack_q;
                  state  <= ST_ACK2;
               end
               ST_ACK2: if (scl_fall) begin
                  bitcnt <= '0;
                  if (!ack_q) begin
                     state  <= ST_IGN;
                     sda_oe <= 1'b0;
                  end else if (to_tx) begin
                     state  <= ST_TX;
                     sda_oe <= ~txsh[7];
                  end else begin
                     state  <= ST_RX;
                     sda_oe <= 1'b0;
                  end
               end
               ST_TX: if (scl_fall) begin
                  if (bitcnt == 3'd7) begin
                     sda_oe <= 1'b0;
                     state  <= ST_TACK;
                  end else begin
                     sda_oe <= ~txsh[6];
                     txsh   <= txsh << 1;
                     bitcnt <= bitcnt + 3'd1;
                  end
               end
               ST_TACK: begin
                  if (scl_rise)
                     acked <= ~sda_s;
                  if (scl_fall) begin
                     if (acked) begin
                        state  <= ST_TX;
                        bitcnt <= '0;
                        if (rd_left != '0) begin
                           txsh    <= rd_data;
                           sda_oe  <= ~rd_data[7];
                           rd_left <= rd_left - 1'b1;
                           idx     <= step_idx(idx);
                        end else begin
                           txsh   <= '1;
                           sda_oe <= 1'b0;
                        end
                     end else begin
                        state  <= ST_IGN;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
   import smb_regbank_pkg::*;
#(
   parameter int         NREG        = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         CNT_IDX     = 7,
   parameter int         CNT_W       = 5,
   parameter logic [6:0] ADDR_LO     = 7'h68,
   parameter logic [6:0] ADDR_HI     = 7'h6A
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   input  logic                   pwrgd_i,
   input  logic                   addr_strap_i,
   output logic                   sda_oe_o,
   output logic [NREG*BYTE_W-1:0] regs_o
);

   if (NREG < CNT_IDX + 1 || NREG > (1 << IDX_W)) begin : g_bad_nreg
      $error("smb_regbank: NREG must cover the count register and fit the index");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("smb_regbank: SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 1 || CNT_W > BYTE_W) begin : g_bad_cnt
      $error("smb_regbank: CNT_W must lie within one byte");
   end

   logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic              pg_q, pg_seen, addr_sel;
   logic [6:0]        my_addr;
   logic [BYTE_W-1:0] cnt_byte;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx, rd_idx;
   logic [BYTE_W-1:0] wr_data, rd_data;
   logic              ignoring;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_q     <= 1'b0;
         pg_seen  <= 1'b0;
         addr_sel <= 1'b0;
      end else begin
         pg_q <= pwrgd_i;
         if (pwrgd_i && !pg_q && !pg_seen) begin
            pg_seen  <= 1'b1;
            addr_sel <= addr_strap_i;
         end
      end
   end

   assign my_addr  = addr_sel ? ADDR_HI : ADDR_LO;
   assign cnt_byte = BYTE_W'(regs_o[CNT_IDX*BYTE_W +: CNT_W]);

   smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   smb_target_fsm #(.NREG(NREG)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_s     (sda_s),
      .addr_ok   (pg_seen),
      .my_addr   (my_addr),
      .cnt_byte  (cnt_byte),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_idx    (rd_idx),
      .sda_oe    (sda_oe_o),
      .ignoring  (ignoring)
   );

   smb_regfile #(.NREG(NREG)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .rd_idx    (rd_idx),
      .rd_data   (rd_data),
      .regs_flat (regs_o)
   );

endmodule

// File: rtl/smb_regbank_chk.sv
module smb_regbank_chk #(
   parameter int VW = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sda_oe_o,
   input logic          scl_s,
   input logic          pg_seen,
   input logic          addr_sel,
   input logic          wr_en,
   input logic          ignoring,
   input logic [VW-1:0] regs_o
);

   // R1: once captured, the address select never moves
   a_r1_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_seen && $past(pg_seen)) |-> $stable(addr_sel));

   // R2: no drive on SDA before the first power-good edge
   a_r2_silent_before_pg: assert property (@(posedge clk) disable iff (!rst_n)
      !pg_seen |-> !sda_oe_o);

   // R3: while ignoring the bus the pad is released
   a_r3_ignore_released: assert property (@(posedge clk) disable iff (!rst_n)
      ignoring |-> !sda_oe_o);

   // R6: SDA drive only starts while SCL is low
   a_r6_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_s);

   // R8: the register vector changes only after a write strobe
   a_r8_write_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> $stable(regs_o));

endmodule

bind smb_regbank smb_regbank_chk #(.VW(NREG*8)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sda_oe_o (sda_oe_o),
   .scl_s    (scl_s),
   .pg_seen  (pg_seen),
   .addr_sel (addr_sel),
   .wr_en    (wr_en),
   .ignoring (ignoring),
   .regs_o   (regs_o)
);

// File: tb/smb_regbank_test.sv
module smb_regbank_test;

   localparam int NR = 8;
   localparam int Q  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_scl = 1'b1;
   logic host_sda = 1'b1;
   logic pwrgd = 1'b0;
   logic strap = 1'b0;
   logic sda_oe;
   logic [NR*8-1:0] regs;
   wire  sda_line = host_sda & ~sda_oe;

   int vectors = 0;
   int fails = 0;
   bit done = 0;

   logic [7:0] model [NR];
   logic       m_pg = 1'b0;
   logic [6:0] m_addr = 7'h68;
   logic [7:0] wbuf [16];

   always #10 clk = ~clk;

   smb_regbank uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (host_scl),
      .sda_i        (sda_line),
      .pwrgd_i      (pwrgd),
      .addr_strap_i (strap),
      .sda_oe_o     (sda_oe),
      .regs_o       (regs)
   );

   function automatic logic [7:0] m_init(int i);
      case (i)
         0, 2: return 8'hFF;
         3: return 8'h10;
         5: return 8'h11;
         6, 7: return 8'h08;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] m_mask(int i);
      case (i)
         0, 2: return 8'hFF;
         1: return 8'h3B;
         3: return 8'hF0;
         7: return 8'h1F;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] nxt(logic [7:0] p);
      return (p < 8'(NR-1)) ? p + 8'd1 : p;
   endfunction

   function automatic logic [7:0] rd_model(logic [7:0] start, int k);
      int cnt = int'(model[7][4:0]);
      logic [7:0] p = start;
      if (k == 0) return {3'b000, model[7][4:0]};
      if (k > cnt) return 8'hFF;
      for (int j = 1; j < k; j++) p = nxt(p);
      return (p < 8'(NR)) ? model[p[2:0]] : 8'h00;
   endfunction

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_regs(string req);
      for (int i = 0; i < NR; i++) chk8(req, regs[i*8 +: 8], model[i]);
   endtask

   task automatic bus_start();
      host_sda = 1'b1; tick(Q);
      host_scl = 1'b1; tick(Q);
      host_sda = 1'b0; tick(Q);
      host_scl = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      host_sda = 1'b0; tick(Q);
      host_scl = 1'b1; tick(Q);
      host_sda = 1'b1; tick(2*Q);
   endtask

   task automatic send_bit(logic b);
      host_sda = b; tick(Q);
      host_scl = 1'b1; tick(2*Q);
      host_scl = 1'b0; tick(Q);
   endtask

   task automatic recv_bit(output logic b);
      host_sda = 1'b1; tick(Q);
      host_scl = 1'b1; tick(Q);
      b = sda_line; tick(Q);
      host_scl = 1'b0; tick(Q);
   endtask

   task automatic send_byte(logic [7:0] d, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(a);
      ack = ~a;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic host_ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         d[i] = b;
      end
      send_bit(~host_ack);
   endtask

   // Block write of n bytes from wbuf; checks every acknowledge and updates the model.
   task automatic do_write(string req, logic [6:0] a, logic [7:0] idx, logic [7:0] cnt, int n);
      logic ack;
      logic hit = m_pg && (a == m_addr);
      logic [7:0] p = idx;
      bus_start();
      send_byte({a, 1'b0}, ack); chk8(req, 8'(ack), 8'(hit));
      send_byte(idx, ack);       chk8(req, 8'(ack), 8'(hit));
      send_byte(cnt, ack);       chk8(req, 8'(ack), 8'(hit));
      for (int k = 0; k < n; k++) begin
         logic exp_ack = hit && (k < int'(cnt));
         send_byte(wbuf[k], ack);
         chk8(req, 8'(ack), 8'(exp_ack));
         if (exp_ack) begin
            if (p < 8'(NR))
               model[p[2:0]] = (model[p[2:0]] & ~m_mask(int'(p))) | (wbuf[k] & m_mask(int'(p)));
            p = nxt(p);
         end
      end
      bus_stop();
      tick(2);
   endtask

   // Index write, repeated START, then n bytes read and compared to the model.
   task automatic do_read(string req, logic [6:0] a, logic [7:0] idx, int n);
      logic ack;
      logic [7:0] d;
      bus_start();
      send_byte({a, 1'b0}, ack); chk8(req, 8'(ack), 8'h01);
      send_byte(idx, ack);       chk8(req, 8'(ack), 8'h01);
      bus_start();
      send_byte({a, 1'b1}, ack); chk8(req, 8'(ack), 8'h01);
      for (int k = 0; k < n; k++) begin
         recv_byte(d, k != n-1);
         chk8(req, d, rd_model(idx, k));
      end
      bus_stop();
      tick(2);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int unsigned seed = $urandom(32'h5EED_0C1A);
      for (int i = 0; i < NR; i++) model[i] = m_init(i);
      tick(5);
      rst_n = 1'b1;
      tick(3);
      chk8("R9 sda released", 8'(sda_oe), 8'h00);
      check_regs("R9 reset map");

      // R2: no response before power-good
      wbuf[0] = 8'h00;
      do_write("R2 before pg", 7'h68, 8'd0, 8'd1, 1);
      check_regs("R2 nothing written");

      // R1: strap rises in the same cycle as power-good, then drops
      strap = 1'b1; pwrgd = 1'b1; m_pg = 1'b1; m_addr = 7'h6A;
      tick(3);
      strap = 1'b0;
      tick(3);

      // R3: wrong address is ignored to the next START
      wbuf[0] = 8'h12; wbuf[1] = 8'h34;
      do_write("R3 wrong addr", 7'h68, 8'd0, 8'd2, 2);
      check_regs("R3 nothing written");

      // R4: basic indexed write with masked register 1
      wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'h3C;
      do_write("R4 block write", 7'h6A, 8'd0, 8'd3, 3);
      check_regs("R4 contents");

      // R5: surplus byte beyond count
      wbuf[0] = 8'h81; wbuf[1] = 8'h7E;
      do_write("R5 surplus nack", 7'h6A, 8'd2, 8'd1, 2);
      check_regs("R5 contents");

      // R8: write ones over read-only and reserved locations
      for (int i = 0; i < 5; i++) wbuf[i] = 8'hFF;
      do_write("R8 ro write", 7'h6A, 8'd3, 8'd5, 5);
      check_regs("R8 masks");
      wbuf[0] = 8'h03;
      do_write("R7 set count", 7'h6A, 8'd7, 8'd1, 1);
      check_regs("R7 count reg");

      // R6 and R7: read with count 3, two trailing bytes
      do_read("R6 R7 read", 7'h6A, 8'd0, 6);

      // R10: saturation at the last register
      wbuf[0] = 8'hE4; wbuf[1] = 8'hE5; wbuf[2] = 8'hE6; wbuf[3] = 8'hE2;
      do_write("R10 saturate write", 7'h6A, 8'd6, 8'd4, 4);
      check_regs("R10 last reg");
      do_read("R10 saturate read", 7'h6A, 8'd6, 5);

      // R10: out-of-range index
      wbuf[0] = 8'h55; wbuf[1] = 8'hAA;
      do_write("R10 oor write", 7'h6A, 8'h20, 8'd2, 2);
      check_regs("R10 oor nothing");
      wbuf[0] = 8'h04;
      do_write("R7 set count", 7'h6A, 8'd7, 8'd1, 1);
      do_read("R10 oor read", 7'h6A, 8'h20, 5);

      // R1: a second power-good pulse with strap low keeps 0x6A
      pwrgd = 1'b0; tick(4); pwrgd = 1'b1; tick(4);
      wbuf[0] = 8'h0F;
      do_write("R1 addr held", 7'h6A, 8'd0, 8'd1, 1);
      wbuf[0] = 8'hF0;
      do_write("R1 old addr nack", 7'h68, 8'd0, 8'd1, 1);
      check_regs("R1 contents");

      // Random transfers against the model
      for (int it = 0; it < 12; it++) begin
         logic [7:0] idx = 8'($urandom % 9);
         int cnt = 1 + int'($urandom % 4);
         int n = cnt + int'($urandom % 2);
         for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
         do_write("R4 R5 random write", 7'h6A, idx, 8'(cnt), n);
         check_regs("R8 random contents");
         do_read("R6 R7 random read", 7'h6A, 8'($urandom % 8), 1 + int'($urandom % 8));
      end

      if (seed == 0) tick(1);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule